// File: doc/BRIEF.md
# Reset-synchronised glitch pulse sequencer

The sequencer produces one fault-injection pulse at an exact cycle offset from the moment a target device leaves reset. A host sends short commands as a stream of already decoded bytes. Commands program a delay and a pulse width, start a single attempt, or step an automatic sweep. One attempt has three phases. The block drives the target's reset line high for a fixed number of cycles and then releases it. It waits the programmed delay. It then holds the power-multiplexer select output high for the programmed width. Every count is made in whole clock cycles from one counter, so the pulse position relative to reset release has no jitter.

Sweep mode keeps its own cursor, made of a delay and a width. Each sweep attempt uses the cursor and then moves it on. The width rises until it reaches its ceiling. The width then returns to its floor and the delay advances by one. At the end of every attempt a one-cycle report gives the delay and width that were used, so the host can log each point.

The byte input is a valid/ready stream. `in_ready` is held high at all times, so the sender never sees back-pressure. A byte is consumed on every clock edge where `in_valid` is high, and the sender may leave gaps of any length between bytes. Commands that complete while an attempt is running are thrown away. Their data bytes are still consumed.

Top module: `fault_pulse_seq`

## Requirements
- R1: `in_ready` is always 1, and a byte is consumed on each edge with `in_valid` high. Opcode 0x01 takes the next 4 bytes as the delay and opcode 0x02 takes the next 2 bytes as the width. In both cases the first data byte is the least significant.
- R2: A byte received when no command is open is taken as an opcode. An opcode other than 0x01 to 0x05 is ignored, and the byte after it is again taken as an opcode.
- R3: Opcode 0x03 starts an attempt with the programmed delay D and width W. `tgt_rst` goes high in the cycle after the opcode byte is taken and stays high for exactly HOLD_CYC cycles.
- R4: Call the first cycle with `tgt_rst` low again release cycle 0. `glitch_sel` first goes high in release cycle D, so with D=0 it rises in the release cycle itself. `glitch_sel` and `tgt_rst` are never high together.
- R5: `glitch_sel` stays high for exactly W consecutive cycles. With W=0 it never goes high during that attempt.
- R6: `done` is high for exactly one cycle, in release cycle D+W. In that cycle `done_delay` equals D, `done_width` equals W, and `busy` is low.
- R7: `busy` is high from the cycle after the starting opcode until the cycle before `done`. Any command whose last byte is taken while `busy` is high has no effect. This covers set commands, run commands and the clear command.
- R8: Opcode 0x04 starts an attempt using the sweep cursor. Afterwards the cursor width rises by 1 if it is below WID_MAX. Otherwise the width returns to WID_MIN and the cursor delay rises by 1. Single attempts started by 0x03 leave the cursor unchanged.
- R9: Opcode 0x05 sets the cursor delay to the programmed delay and the cursor width to WID_MIN.
- R10: After reset, `tgt_rst`, `glitch_sel`, `busy` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every count is made in cycles of this clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command byte valid |
| in_ready | output | 1 | Command byte ready (always 1) |
| in_data | input | 8 | Command byte |
| tgt_rst | output | 1 | Target reset, active high |
| glitch_sel | output | 1 | Power multiplexer select; high selects the glitch voltage |
| busy | output | 1 | An attempt is in progress |
| done | output | 1 | One-cycle end-of-attempt strobe |
| done_delay | output | 32 | Delay used by the attempt that just ended |
| done_width | output | 16 | Width used by the attempt that just ended |

## Verification
The bench builds the block with HOLD_CYC=4, WID_MIN=1 and WID_MAX=3. The short reset hold keeps each attempt to a few cycles, which leaves room for commands to arrive inside the busy window. The small width range makes the sweep wrap, and the delay step after it, happen within a handful of attempts. A monitor measures the reset length, the offset from release to pulse start, the pulse length and the position of `done`. It compares each of these with values queued by the driver. Any `done` that was not expected reveals a command that should have been dropped.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int DLY_BYTES = 4;
  localparam int WID_BYTES = 2;
  localparam int DLY_W     = 8 * DLY_BYTES;
  localparam int WID_W     = 8 * WID_BYTES;
  localparam int IDX_W     = $clog2(DLY_BYTES);

  localparam logic [7:0] OP_SET_DLY = 8'h01;
  localparam logic [7:0] OP_SET_WID = 8'h02;
  localparam logic [7:0] OP_RUN_ONE = 8'h03;
  localparam logic [7:0] OP_RUN_SWP = 8'h04;
  localparam logic [7:0] OP_CLR_SWP = 8'h05;

  typedef struct packed {
    logic set_dly;
    logic set_wid;
    logic run_one;
    logic run_swp;
    logic clr_swp;
  } cmd_ev_t;

  typedef enum logic [1:0] {T_IDLE, T_HOLD, T_WAIT, T_FIRE} tstate_e;
endpackage

// File: rtl/fps_byte_parser.sv
module fps_byte_parser
  import fps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output cmd_ev_t          ev,
  output logic [DLY_W-1:0] ev_val
);
  logic             open_q;
  logic [7:0]       op_q;
  logic [IDX_W-1:0] idx_q;
  logic [DLY_W-1:0] acc_q;
  logic [IDX_W-1:0] last_idx;
  logic [DLY_W-1:0] merged;
  logic             last_byte;
  logic             opens;

  assign in_ready  = 1'b1;
  assign last_idx  = (op_q == OP_SET_DLY) ? IDX_W'(DLY_BYTES - 1) : IDX_W'(WID_BYTES - 1);
  assign merged    = acc_q | (DLY_W'(in_data) << {idx_q, 3'b000});
  assign last_byte = open_q && (idx_q == last_idx);
  assign opens     = !open_q && ((in_data == OP_SET_DLY) || (in_data == OP_SET_WID));
  assign ev_val    = merged;

  always_comb begin
    ev = '0;
    if (in_valid) begin
      if (!open_q) begin
        ev.run_one = (in_data == OP_RUN_ONE);
        ev.run_swp = (in_data == OP_RUN_SWP);
        ev.clr_swp = (in_data == OP_CLR_SWP);
      end else if (last_byte) begin
        ev.set_dly = (op_q == OP_SET_DLY);
        ev.set_wid = (op_q == OP_SET_WID);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      op_q   <= '0;
      idx_q  <= '0;
      acc_q  <= '0;
    end else if (in_valid) begin
      if (opens) begin
        open_q <= 1'b1;
        op_q   <= in_data;
        idx_q  <= '0;
        acc_q  <= '0;
      end else if (last_byte) begin
        open_q <= 1'b0;
      end else if (open_q) begin
        idx_q <= idx_q + 1'b1;
        acc_q <= merged;
      end
    end
  end

  // R1
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (idx_q <= last_idx));
endmodule

// File: rtl/fps_point_regs.sv
module fps_point_regs
  import fps_pkg::*;
#(
  parameter int WID_MIN = 1,
  parameter int WID_MAX = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_ev_t          ev,
  input  logic [DLY_W-1:0] ev_val,
  input  logic             busy,
  input  logic             finish,
  output logic             start,
  output logic [DLY_W-1:0] run_dly,
  output logic [WID_W-1:0] run_wid
);
  localparam logic [WID_W-1:0] W_LO = WID_W'(WID_MIN);
  localparam logic [WID_W-1:0] W_HI = WID_W'(WID_MAX);

  logic [DLY_W-1:0] prog_dly, sw_dly;
  logic [WID_W-1:0] prog_wid, sw_wid;
  logic             sweep_q;
  logic             accept;

  assign accept  = !busy;
  assign start   = accept && (ev.run_one || ev.run_swp);
  assign run_dly = ev.run_swp ? sw_dly : prog_dly;
  assign run_wid = ev.run_swp ? sw_wid : prog_wid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_dly <= '0;
      prog_wid <= '0;
      sw_dly   <= '0;
      sw_wid   <= W_LO;
      sweep_q  <= 1'b0;
    end else begin
      if (accept && ev.set_dly) prog_dly <= ev_val;
      if (accept && ev.set_wid) prog_wid <= ev_val[WID_W-1:0];
      if (accept && ev.clr_swp) begin
        sw_dly <= prog_dly;
        sw_wid <= W_LO;
      end
      if (start) sweep_q <= ev.run_swp;
      if (finish && sweep_q) begin
        if (sw_wid >= W_HI) begin
          sw_wid <= W_LO;
          sw_dly <= sw_dly + 1'b1;
        end else begin
          sw_wid <= sw_wid + 1'b1;
        end
      end
    end
  end

  // R8
  sw_wid_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wid >= W_LO) && (sw_wid <= W_HI));
  // R7
  prog_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(prog_dly) && $stable(prog_wid)));
endmodule

// File: rtl/fps_run_timer.sv
module fps_run_timer
  import fps_pkg::*;
#(
  parameter int HOLD_CYC = 1200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DLY_W-1:0] run_dly,
  input  logic [WID_W-1:0] run_wid,
  output logic             tgt_rst,
  output logic             glitch_sel,
  output logic             busy,
  output logic             done,
  output logic [DLY_W-1:0] done_delay,
  output logic [WID_W-1:0] done_width,
  output logic             finish
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam int CNT_W  = (DLY_W > HOLD_W) ? DLY_W : HOLD_W;

  tstate_e          state;
  logic [CNT_W-1:0] cnt;
  logic [DLY_W-1:0] dly_q;
  logic [WID_W-1:0] wid_q;
  logic             cnt_end;

  assign cnt_end    = (cnt == '0);
  assign busy       = (state != T_IDLE);
  assign done_delay = dly_q;
  assign done_width = wid_q;
  assign finish     = cnt_end && (((state == T_HOLD) && (dly_q == '0) && (wid_q == '0)) ||
                                  ((state == T_WAIT) && (wid_q == '0)) ||
                                  (state == T_FIRE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= T_IDLE;
      cnt        <= '0;
      dly_q      <= '0;
      wid_q      <= '0;
      tgt_rst    <= 1'b0;
      glitch_sel <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        T_IDLE: if (start) begin
          state   <= T_HOLD;
          cnt     <= CNT_W'(HOLD_CYC - 1);
          dly_q   <= run_dly;
          wid_q   <= run_wid;
          tgt_rst <= 1'b1;
        end
        T_HOLD: if (cnt_end) begin
          tgt_rst <= 1'b0;
          if (dly_q != '0) begin
            state <= T_WAIT;
            cnt   <= CNT_W'(dly_q - 1'b1);
          end else if (wid_q != '0) begin
            state      <= T_FIRE;
            glitch_sel <= 1'b1;
            cnt        <= CNT_W'(wid_q - 1'b1);
          end else begin
            state <= T_IDLE;
            done  <= 1'b1;
          end
        end else cnt <= cnt - 1'b1;
        T_WAIT: if (cnt_end) begin
          if (wid_q != '0) begin
            state      <= T_FIRE;
            glitch_sel <= 1'b1;
            cnt        <= CNT_W'(wid_q - 1'b1);
          end else begin
            state <= T_IDLE;
            done  <= 1'b1;
          end
        end else cnt <= cnt - 1'b1;
        default: if (cnt_end) begin
          glitch_sel <= 1'b0;
          state      <= T_IDLE;
          done       <= 1'b1;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  // R4
  glitch_rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(glitch_sel && tgt_rst));
  // R6
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R3
  rst_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_rst) |-> busy);
endmodule

// File: rtl/fault_pulse_seq.sv
module fault_pulse_seq
  import fps_pkg::*;
#(
  parameter int HOLD_CYC = 1200,
  parameter int WID_MIN  = 1,
  parameter int WID_MAX  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             tgt_rst,
  output logic             glitch_sel,
  output logic             busy,
  output logic             done,
  output logic [DLY_W-1:0] done_delay,
  output logic [WID_W-1:0] done_width
);
  cmd_ev_t          ev;
  logic [DLY_W-1:0] ev_val;
  logic             start, finish;
  logic [DLY_W-1:0] run_dly;
  logic [WID_W-1:0] run_wid;

  fps_byte_parser i_parse (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .ev(ev), .ev_val(ev_val)
  );

  fps_point_regs #(.WID_MIN(WID_MIN), .WID_MAX(WID_MAX)) i_regs (
    .clk(clk), .rst_n(rst_n), .ev(ev), .ev_val(ev_val), .busy(busy),
    .finish(finish), .start(start), .run_dly(run_dly), .run_wid(run_wid)
  );

  fps_run_timer #(.HOLD_CYC(HOLD_CYC)) i_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .run_dly(run_dly), .run_wid(run_wid),
    .tgt_rst(tgt_rst), .glitch_sel(glitch_sel), .busy(busy), .done(done),
    .done_delay(done_delay), .done_width(done_width), .finish(finish)
  );
endmodule

// File: tb/test_fault_pulse_seq.sv
`timescale 1ns/1ps
module test_fault_pulse_seq;
  localparam int H = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, tgt_rst, glitch_sel, busy, done;
  logic [31:0] done_delay;
  logic [15:0] done_width;

  always #2 clk = ~clk;

  fault_pulse_seq #(.HOLD_CYC(H), .WID_MIN(1), .WID_MAX(3)) i_fault_pulse_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .tgt_rst(tgt_rst), .glitch_sel(glitch_sel), .busy(busy),
    .done(done), .done_delay(done_delay), .done_width(done_width)
  );

  typedef struct { int d; int w; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  int  rst_len = 0, since = 0, gap = -1, glen = 0;
  bit  prev_rst = 0, rel = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tgt_rst) begin
        if (!prev_rst) rst_len = 0;
        rst_len++;
        rel = 0;
      end else if (prev_rst) begin
        rel = 1; since = 0; gap = -1; glen = 0;
      end else if (rel) since++;
      if (glitch_sel) begin
        if (gap < 0) gap = since;
        glen++;
      end
      if (done) begin
        if (q.size() == 0) begin
          chk(0, "R7 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(rst_len == H, "R3 reset length", rst_len, H);
          chk(gap == ((e.w == 0) ? -1 : e.d), "R4 pulse offset", gap, (e.w == 0) ? -1 : e.d);
          chk(glen == e.w, "R5 pulse length", glen, e.w);
          chk(since == e.d + e.w, "R6 done position", since, e.d + e.w);
          chk(int'(done_delay) == e.d, "R6 done_delay", done_delay, e.d);
          chk(int'(done_width) == e.w, "R6 done_width", done_width, e.w);
          chk(!busy, "R6 busy low at done", busy, 0);
        end
        rel = 0;
      end
      prev_rst = tgt_rst;
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask
  task automatic set_dly(input int v);
    send(8'h01);
    for (int i = 0; i < 4; i++) send(8'(v >> (8 * i)));
  endtask
  task automatic set_wid(input int v);
    send(8'h02);
    send(8'(v)); send(8'(v >> 8));
  endtask
  task automatic expect_run(input logic [7:0] op, input int d, input int w);
    exp_t e;
    e.d = d; e.w = w;
    q.push_back(e);
    send(op);
  endtask
  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0 || busy);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R6 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!tgt_rst && !glitch_sel && !busy && !done, "R10 outputs after reset",
        {tgt_rst, glitch_sel, busy, done}, 0);
    chk(in_ready, "R1 in_ready", in_ready, 1);

    // R1 R3 R4 R5 R6: plain attempt
    set_dly(5); set_wid(2);
    expect_run(8'h03, 5, 2);
    chk(busy, "R7 busy after start", busy, 1);
    wait_idle();

    // R4: zero delay
    set_dly(0); set_wid(3);
    expect_run(8'h03, 0, 3); wait_idle();

    // R5: zero width
    set_dly(2); set_wid(0);
    expect_run(8'h03, 2, 0); wait_idle();

    // R2: unknown opcode followed by run
    send(8'h09);
    send(8'hA5);
    expect_run(8'h03, 2, 0); wait_idle();

    // R1: multi-byte delay, least significant byte first
    set_dly(259); set_wid(1);
    expect_run(8'h03, 259, 1); wait_idle();

    // R7: commands while busy are dropped
    set_dly(6); set_wid(2);
    expect_run(8'h03, 6, 2);
    set_wid(9);
    send(8'h03);
    set_dly(1);
    wait_idle();
    expect_run(8'h03, 6, 2); wait_idle();

    // R9 R8: sweep from programmed delay, wrap at WID_MAX
    set_dly(10);
    send(8'h05);
    expect_run(8'h04, 10, 1); wait_idle();
    expect_run(8'h04, 10, 2); wait_idle();
    expect_run(8'h04, 10, 3); wait_idle();
    expect_run(8'h04, 11, 1); wait_idle();
    // R8: single attempt does not move cursor
    expect_run(8'h03, 10, 2); wait_idle();
    expect_run(8'h04, 11, 2); wait_idle();
    // R9: clear restarts cursor
    send(8'h05);
    expect_run(8'h04, 10, 1); wait_idle();

    chk(q.size() == 0, "R6 all reports seen", q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule